// File: doc/BRIEF.md
# Collision Auto-Partition Controller

This block watches one repeater port for unhealthy collision behaviour and isolates it. When a single collision goes on too long, or when a long enough run of transmit attempts to the port all collide, the block raises a partitioned flag. The repeater arbiter uses that flag to stop treating the port's receiver as a source of traffic. Frames are still sent to the port while it is partitioned.

The block clears the flag once the port carries a clean frame that is long enough. Two clearing rules are available. The standard rule accepts a clean frame in either direction. The alternate rule accepts only a clean frame that the port transmits.

How a collision is recognised depends on the port type. On an attachment-unit port it is the SQE input. On a twisted-pair port it is transmit and receive being active together. All timing is counted in bit times, using a one-cycle bit-time enable. The repeater uses one instance per port, and no instance depends on any other.

Top module: `port_isolator`

## Requirements
- R1: The collision condition is `sqe` when `is_aui`=1, and `tx_act & rx_act` when `is_aui`=0. On a twisted-pair port, receive activity alone is never a collision, and neither is `sqe`.
- R2: If the collision condition holds for LONG_BITS (default 1536) consecutive bit ticks, the port partitions on the last of those ticks. A collision of LONG_BITS-1 ticks does not partition the port.
- R3: A transmit attempt is a run of ticks with `tx_act`=1. It ends at the first tick with `tx_act`=0. An attempt that saw a collision while `tx_act` was high is counted. When the ATTEMPT_LIMIT-th (default 32) consecutive counted attempt ends, the port partitions. Any partition clears the attempt count.
- R4: An attempt that lasts more than GOOD_LEN (default 512) ticks without a collision resets the attempt count to zero.
- R5: An attempt that is free of collisions but lasts GOOD_LEN ticks or fewer leaves the attempt count unchanged.
- R6: With `alt_rule`=0, the partition clears when an activity run ends. Here activity means `tx_act | rx_act`. The run must last more than GOOD_LEN ticks and contain no collision.
- R7: With `alt_rule`=1, only a transmit run can clear the partition. Receive-only runs of any length leave the port partitioned.
- R8: A collision anywhere within a candidate run cancels that run as a reconnection candidate. A run of exactly GOOD_LEN ticks does not reconnect the port.
- R9: State advances only on cycles with `bit_en`=1. On other cycles `part_o` holds its value.
- R10: A synchronous active-high `rst` clears `part_o`, the attempt count and all timers.
- R11: `part_o` is registered. It changes in the clock cycle after the bit tick that completes its condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle pulse per bit time |
| tx_act | input | 1 | Repeater is transmitting to this port |
| rx_act | input | 1 | Port receiver is active |
| sqe | input | 1 | Collision presence from an attachment-unit port |
| is_aui | input | 1 | 1 = attachment-unit port, 0 = twisted-pair port |
| alt_rule | input | 1 | 0 = standard reconnection, 1 = transmit-only reconnection |
| part_o | output | 1 | Port is partitioned |

## Verification
Two partition triggers can complete on the same bit tick: the long-collision timer and the ending of the last allowed colliding attempt. The bench sets this up on an attachment-unit port. It first runs 31 colliding attempts. It then holds SQE long enough that the SQE run reaches LONG_BITS on exactly the tick at which the 32nd colliding attempt ends, because transmit drops while SQE stays high. The bench judges the result in three steps. The flag must rise once, in the next cycle. A clean transmit must then clear it. A further 31 colliding attempts must not partition the port again, which shows that the coinciding triggers left the attempt count at zero.

// File: rtl/iso_pkg.sv
package iso_pkg;
  typedef enum logic {
    PORT_TP  = 1'b0,
    PORT_AUI = 1'b1
  } port_kind_e;
endpackage

// File: rtl/coll_sense.sv
module coll_sense
  import iso_pkg::*;
(
  input  port_kind_e kind,
  input  logic       tx_act,
  input  logic       rx_act,
  input  logic       sqe,
  output logic       coll
);
  always_comb begin
    case (kind)
      PORT_AUI: coll = sqe;
      default:  coll = tx_act & rx_act;
    endcase
  end
endmodule

// File: rtl/coll_timer.sv
module coll_timer #(
  parameter int LONG_BITS = 1536
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic coll,
  output logic trip
);
  localparam int TW = $clog2(LONG_BITS + 1);
  localparam logic [TW-1:0] TOP  = TW'(LONG_BITS);
  localparam logic [TW-1:0] LAST = TW'(LONG_BITS - 1);

  logic [TW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (tick) begin
      if (!coll)            run_q <= '0;
      else if (run_q != TOP) run_q <= run_q + 1'b1;
    end
  end

  assign trip = tick & coll & (run_q == LAST);
endmodule

// File: rtl/burst_gauge.sv
module burst_gauge #(
  parameter int GOOD_LEN = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  input  logic coll,
  output logic done_clean,
  output logic done_dirty
);
  localparam int LW = $clog2(GOOD_LEN + 2);
  localparam logic [LW-1:0] LEN_SAT = LW'(GOOD_LEN + 1);
  localparam logic [LW-1:0] LEN_MIN = LW'(GOOD_LEN);

  logic          run_q;
  logic          hit_q;
  logic [LW-1:0] len_q;
  logic          ending;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      hit_q <= 1'b0;
      len_q <= '0;
    end else if (tick) begin
      run_q <= active;
      if (active) begin
        hit_q <= hit_q | coll;
        if (len_q != LEN_SAT) len_q <= len_q + 1'b1;
      end else begin
        hit_q <= 1'b0;
        len_q <= '0;
      end
    end
  end

  assign ending     = tick & run_q & ~active;
  assign done_dirty = ending & hit_q;
  assign done_clean = ending & ~hit_q & (len_q > LEN_MIN);
endmodule

// File: rtl/port_isolator.sv
module port_isolator
  import iso_pkg::*;
#(
  parameter int LONG_BITS     = 1536,
  parameter int ATTEMPT_LIMIT = 32,
  parameter int GOOD_LEN      = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic tx_act,
  input  logic rx_act,
  input  logic sqe,
  input  logic is_aui,
  input  logic alt_rule,
  output logic part_o
);
  localparam int CW = $clog2(ATTEMPT_LIMIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(ATTEMPT_LIMIT - 1);
  localparam int N_GAUGE = 2;   // 0: transmit attempts, 1: reconnection runs

  logic          coll;
  logic          trip;
  logic          rc_act;
  logic          part_q;
  logic [CW-1:0] attempts_q;
  logic [N_GAUGE-1:0] g_act, g_clean, g_dirty;

  coll_sense u_sense (
    .kind   (port_kind_e'(is_aui)),
    .tx_act (tx_act),
    .rx_act (rx_act),
    .sqe    (sqe),
    .coll   (coll)
  );

  coll_timer #(.LONG_BITS(LONG_BITS)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (bit_en),
    .coll (coll),
    .trip (trip)
  );

  assign rc_act   = alt_rule ? tx_act : (tx_act | rx_act);
  assign g_act[0] = tx_act;
  assign g_act[1] = rc_act;

  for (genvar g = 0; g < N_GAUGE; g++) begin : g_gauge
    burst_gauge #(.GOOD_LEN(GOOD_LEN)) u_gauge (
      .clk        (clk),
      .rst        (rst),
      .tick       (bit_en),
      .active     (g_act[g]),
      .coll       (coll),
      .done_clean (g_clean[g]),
      .done_dirty (g_dirty[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q     <= 1'b0;
      attempts_q <= '0;
    end else if (bit_en) begin
      if (!part_q) begin
        if (trip || (g_dirty[0] && attempts_q == CNT_LAST)) begin
          part_q     <= 1'b1;
          attempts_q <= '0;
        end else if (g_dirty[0]) begin
          attempts_q <= attempts_q + 1'b1;
        end else if (g_clean[0]) begin
          attempts_q <= '0;
        end
      end else if (g_clean[1]) begin
        part_q <= 1'b0;
      end
    end
  end

  assign part_o = part_q;
endmodule

// File: rtl/iso_checker.sv
module iso_checker #(
  parameter int LONG_BITS = 1536
) (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic tx_act,
  input logic rx_act,
  input logic sqe,
  input logic is_aui,
  input logic part_o
);
  localparam int KW = $clog2(LONG_BITS + 1);
  logic [KW-1:0] ck_run;
  logic          ck_coll;

  assign ck_coll = is_aui ? sqe : (tx_act & rx_act);

  always_ff @(posedge clk) begin
    if (rst) ck_run <= '0;
    else if (bit_en) begin
      if (!ck_coll) ck_run <= '0;
      else if (ck_run != KW'(LONG_BITS)) ck_run <= ck_run + 1'b1;
    end
  end

  // R2: a collision reaching the threshold leaves the port partitioned
  p_long_trip_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_en && ck_coll && ck_run == KW'(LONG_BITS - 1)) |=> part_o);

  // R9: nothing moves between bit ticks
  p_tick_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(part_o));

  // R6: reconnection only at the end of a run, so transmit is idle then
  p_reconnect_idle_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(part_o) |-> ($past(bit_en) && !$past(tx_act)));

  // R11: partition follows a bit tick
  p_rise_on_tick_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(part_o) |-> $past(bit_en));

  // R10: reset clears the flag
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> !part_o);
endmodule

bind port_isolator iso_checker #(.LONG_BITS(LONG_BITS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .bit_en (bit_en),
  .tx_act (tx_act),
  .rx_act (rx_act),
  .sqe    (sqe),
  .is_aui (is_aui),
  .part_o (part_o)
);

// File: tb/port_isolator_test.sv
module port_isolator_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, tx_act = 1'b0, rx_act = 1'b0, sqe = 1'b0;
  logic is_aui = 1'b0, alt_rule = 1'b0;
  logic part_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  port_isolator uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_act(tx_act), .rx_act(rx_act),
    .sqe(sqe), .is_aui(is_aui), .alt_rule(alt_rule), .part_o(part_o)
  );

  typedef struct packed {
    logic        tx, rx, sq, aui, alt;
    logic [11:0] len;
    logic        exp;
    logic [3:0]  req;
  } seg_t;

  localparam int NSEG = 15;
  localparam seg_t PLAN [NSEG] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,12'd4,   1'b0,4'd10}, // R10 idle after reset
    '{1'b1,1'b1,1'b0,1'b0,1'b0,12'd1535,1'b0,4'd2},  // R2 one short of limit
    '{1'b0,1'b0,1'b0,1'b0,1'b0,12'd2,   1'b0,4'd2},  // R2
    '{1'b1,1'b1,1'b0,1'b0,1'b0,12'd1536,1'b1,4'd2},  // R2 / R11 trips on last tick
    '{1'b0,1'b0,1'b0,1'b0,1'b0,12'd2,   1'b1,4'd11}, // R11 stays set
    '{1'b0,1'b1,1'b0,1'b0,1'b0,12'd513, 1'b1,4'd6},  // R6 run not ended yet
    '{1'b0,1'b0,1'b0,1'b0,1'b0,12'd1,   1'b0,4'd6},  // R6 clean receive reconnects
    '{1'b0,1'b1,1'b0,1'b0,1'b0,12'd1600,1'b0,4'd1},  // R1 receive alone on TP
    '{1'b0,1'b0,1'b0,1'b0,1'b0,12'd1,   1'b0,4'd1},  // R1
    '{1'b0,1'b0,1'b1,1'b1,1'b0,12'd1536,1'b1,4'd1},  // R1 SQE on attachment port
    '{1'b0,1'b0,1'b0,1'b1,1'b0,12'd1,   1'b1,4'd1},  // R1
    '{1'b0,1'b1,1'b0,1'b0,1'b1,12'd600, 1'b1,4'd7},  // R7 receive ignored
    '{1'b0,1'b0,1'b0,1'b0,1'b1,12'd1,   1'b1,4'd7},  // R7
    '{1'b1,1'b0,1'b0,1'b0,1'b1,12'd600, 1'b1,4'd7},  // R7 transmit run
    '{1'b0,1'b0,1'b0,1'b0,1'b1,12'd1,   1'b0,4'd7}   // R7 transmit reconnects
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: part_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; holds values for n rising edges, returns at a falling edge.
  task automatic drive(input logic t, input logic r, input logic s, input logic a,
                       input logic al, input logic en, input int n);
    tx_act = t; rx_act = r; sqe = s; is_aui = a; alt_rule = al; bit_en = en;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 1, 3);
    rst = 1'b0;
  endtask

  task automatic dirty_attempts(input logic a, input int n);
    for (int k = 0; k < n; k++) begin
      if (a) drive(1, 0, 1, 1, 0, 1, 3);
      else   drive(1, 1, 0, 0, 0, 1, 3);
      drive(0, 0, 0, a, 0, 1, 1);
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check("R10", part_o, 1'b0);

    for (int i = 0; i < NSEG; i++) begin
      drive(PLAN[i].tx, PLAN[i].rx, PLAN[i].sq, PLAN[i].aui, PLAN[i].alt, 1, int'(PLAN[i].len));
      check($sformatf("R%0d row %0d", PLAN[i].req, i), part_o, PLAN[i].exp);
    end

    // R10: reset while partitioned
    drive(1, 1, 0, 0, 0, 1, 1536);
    check("R2", part_o, 1'b1);
    do_reset();
    check("R10", part_o, 1'b0);

    // R3: 31 colliding attempts hold, the 32nd partitions
    dirty_attempts(0, 31);
    check("R3", part_o, 1'b0);
    dirty_attempts(0, 1);
    check("R3", part_o, 1'b1);

    // R8: collision inside the candidate run cancels it
    drive(1, 0, 0, 0, 0, 1, 300);
    drive(1, 1, 0, 0, 0, 1, 10);
    drive(1, 0, 0, 0, 0, 1, 300);
    drive(0, 0, 0, 0, 0, 1, 1);
    check("R8", part_o, 1'b1);
    drive(1, 0, 0, 0, 0, 1, 512);
    drive(0, 0, 0, 0, 0, 1, 1);
    check("R8", part_o, 1'b1);
    drive(1, 0, 0, 0, 0, 1, 513);
    drive(0, 0, 0, 0, 0, 1, 1);
    check("R6", part_o, 1'b0);

    // R4: a long clean attempt clears the count
    do_reset();
    dirty_attempts(0, 31);
    drive(1, 0, 0, 0, 0, 1, 513);
    drive(0, 0, 0, 0, 0, 1, 1);
    dirty_attempts(0, 31);
    check("R4", part_o, 1'b0);
    dirty_attempts(0, 1);
    check("R4", part_o, 1'b1);

    // R5: a short clean attempt keeps the count
    do_reset();
    dirty_attempts(0, 20);
    drive(1, 0, 0, 0, 0, 1, 512);
    drive(0, 0, 0, 0, 0, 1, 1);
    dirty_attempts(0, 11);
    check("R5", part_o, 1'b0);
    dirty_attempts(0, 1);
    check("R5", part_o, 1'b1);

    // R9: no ticks, no progress; then ticks on alternate cycles
    do_reset();
    drive(1, 1, 0, 0, 0, 0, 2000);
    check("R9", part_o, 1'b0);
    for (int c = 0; c < 3070; c++) drive(1, 1, 0, 0, 0, (c % 2 == 0), 1);
    check("R9", part_o, 1'b0);
    drive(1, 1, 0, 0, 0, 1, 1);
    check("R9", part_o, 1'b1);
    drive(1, 1, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 1, 2);

    // R2 + R3 coinciding on an attachment port
    do_reset();
    dirty_attempts(1, 31);
    drive(0, 0, 1, 1, 0, 1, 1533);
    drive(1, 0, 1, 1, 0, 1, 2);
    check("R2", part_o, 1'b0);
    drive(0, 0, 1, 1, 0, 1, 1);
    check("R3", part_o, 1'b1);
    drive(0, 0, 0, 1, 0, 1, 2);
    drive(1, 0, 0, 1, 0, 1, 513);
    drive(0, 0, 0, 1, 0, 1, 1);
    check("R6", part_o, 1'b0);
    dirty_attempts(1, 31);
    check("R3", part_o, 1'b0);
    dirty_attempts(1, 1);
    check("R3", part_o, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule